// File: doc/BRIEF.md
# KCS Response Tag Matcher

This block sits between a keyboard-controller-style host message engine and the management-controller back end that produces replies. Every request handed to the back end carries an 8-bit tag, which is the current expected-tag value. A reply arrives as a byte stream with its tag and its total length held steady for the whole message. The reply is copied into the engine's response buffer through a registered write port only when its tag equals the expected tag. A completed copy advances the expected tag and raises a one-cycle ready pulse toward the engine.

An abort from the engine also advances the expected tag. Any reply still in flight for the abandoned request therefore fails the tag compare and is dropped without a trace. An abort that lands while an accepted reply is streaming stops the copy at that beat. A reply longer than the buffer is not copied in full. Its first two bytes are kept, a third byte carrying the "cannot return requested number of bytes" completion code (0xCA) is put in their place, and the reported length becomes 3. The request hand-off strobe also tells the engine to rewind its read position to zero.

Top module: `kcs_rsp_tag_match`

## Requirements
- R1: After reset the expected tag is 0, the request hand-off strobe, buffer write enable and response-ready pulse are low, and the reported length is 0.
- R2: A request-issue strobe sampled at a clock edge gives exactly one cycle of `req_valid_o` after that edge. `req_tag_o` holds the expected tag as it stood before that edge. This strobe also tells the engine to reset its read position to zero.
- R3: A reply whose tag equals the expected tag and whose length is at most the buffer depth writes byte i of the stream to buffer address i, for every byte, in the cycle after that byte is sampled.
- R4: Accepting the final byte of a matching reply advances the expected tag by one, wrapping from 255 to 0.
- R5: A reply whose tag differs from the expected tag is consumed with no buffer write and no ready pulse, and the expected tag does not change.
- R6: An abort advances the expected tag by one. If the abort coincides with a beat of an accepted reply, that beat and every later beat of the reply write nothing, and no ready pulse follows. The same cycle never gives a second increment.
- R7: A matching reply whose length exceeds the buffer depth writes only addresses 0 and 1 with its first two bytes and address 2 with 0xCA, and it reports length 3.
- R8: A matching reply whose length equals the buffer depth is copied whole and reports that length.
- R9: `rsp_ready_o` is high in every cycle after the first clock edge out of reset, whatever the tag of the reply.
- R10: `rsp_done_o` is high for exactly one cycle, two clock edges after the edge that samples the final byte of an accepted reply. `rsp_len_o` carries that reply's recorded length from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_issue_i | input | 1 | Engine hands a request to the back end |
| abort_i | input | 1 | Engine abandons the outstanding request |
| req_valid_o | output | 1 | Registered hand-off strobe; also rewinds the read position |
| req_tag_o | output | 8 | Tag attached to the handed-off request |
| rsp_valid_i | input | 1 | Reply byte present |
| rsp_tag_i | input | 8 | Tag of the reply, steady for the whole message |
| rsp_len_i | input | LEN_W | Total reply length in bytes, steady for the whole message |
| rsp_data_i | input | 8 | Reply byte |
| rsp_last_i | input | 1 | Marks the final byte of the reply |
| rsp_ready_o | output | 1 | Reply bytes are always consumed |
| buf_we_o | output | 1 | Response buffer write enable |
| buf_addr_o | output | AW | Response buffer write address |
| buf_wdata_o | output | 8 | Response buffer write data |
| rsp_len_o | output | LEN_W | Recorded length of the last accepted reply |
| rsp_done_o | output | 1 | One-cycle response-ready pulse |

## Verification
The bench targets the tag boundaries. These are a stale reply arriving after an abort, which a design comparing against a stale tag would copy, and the 255-to-0 wrap, which a design without a clean wrap would miss. It drives replies of exactly buffer depth and of one byte more. Here an off-by-one in the oversize compare shows up as a truncated full-size reply or an overrun buffer. Aborts fall on the middle beat of an accepted reply. A design that ignored them would keep writing and raise a ready pulse, and one that double-counted would skip a tag. The timing of the ready pulse and the order of write addresses are checked on every reply, so a missing pipeline stage or a misplaced 0xCA substitution is caught.

// File: rtl/kcs_tm_pkg.sv
package kcs_tm_pkg;
  localparam int unsigned TAG_W = 8;
  localparam int unsigned BYTE_W = 8;
  // completion code placed in byte 2 of an oversize reply
  localparam logic [BYTE_W-1:0] CC_TOO_LONG = 8'hCA;
  // length reported for an oversize reply
  localparam int unsigned TRUNC_LEN = 3;
endpackage

// File: rtl/kcs_tag_ctr.sv
module kcs_tag_ctr
  import kcs_tm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bump_i,
  output logic [TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (bump_i) begin
      tag_q <= tag_q + 1'b1;
    end
  end

  assign tag_o = tag_q;
endmodule

// File: rtl/kcs_rsp_capture.sv
module kcs_rsp_capture
  import kcs_tm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  exp_tag_i,
  input  logic              abort_i,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [LEN_W-1:0]  rsp_len_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  input  logic              rsp_last_i,
  output logic              accept_o,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [BYTE_W-1:0] buf_wdata_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic              rsp_done_o
);
  localparam logic [LEN_W-1:0] CAP_L   = LEN_W'(DEPTH);
  localparam logic [LEN_W-1:0] TRUNC_L = LEN_W'(TRUNC_LEN);
  localparam logic [LEN_W-1:0] CC_IDX  = LEN_W'(TRUNC_LEN - 1);

  logic              in_msg_q;
  logic              keep_q;
  logic [LEN_W-1:0]  idx_q;
  logic              fin_q;
  logic [LEN_W-1:0]  pend_len_q;
  logic              we_q;
  logic [AW-1:0]     addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q;

  logic              first_beat;
  logic              keep_now;
  logic [LEN_W-1:0]  beat_idx;
  logic              oversize;
  logic              wr_ok;
  logic [BYTE_W-1:0] wr_byte;
  logic              fin_now;

  always_comb begin
    first_beat = rsp_valid_i && !in_msg_q;
    keep_now   = (first_beat ? (rsp_tag_i == exp_tag_i) : keep_q) && !abort_i;
    beat_idx   = first_beat ? '0 : idx_q;
    oversize   = rsp_len_i > CAP_L;
    wr_ok      = keep_now && (oversize ? (beat_idx < TRUNC_L) : (beat_idx < CAP_L));
    wr_byte    = (oversize && (beat_idx == CC_IDX)) ? CC_TOO_LONG : rsp_data_i;
    fin_now    = rsp_valid_i && rsp_last_i && keep_now;
  end

  // message framing and accept decision
  always_ff @(posedge clk) begin
    if (rst) begin
      in_msg_q <= 1'b0;
      keep_q   <= 1'b0;
      idx_q    <= '0;
    end else if (rsp_valid_i) begin
      in_msg_q <= !rsp_last_i;
      keep_q   <= keep_now && !rsp_last_i;
      idx_q    <= beat_idx + 1'b1;
    end else if (abort_i) begin
      keep_q   <= 1'b0;
    end
  end

  // registered buffer write port
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q    <= rsp_valid_i && wr_ok;
      addr_q  <= beat_idx[AW-1:0];
      wdata_q <= wr_byte;
    end
  end

  // completion: length staged with the last write, pulse one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      fin_q      <= 1'b0;
      pend_len_q <= '0;
      len_q      <= '0;
      done_q     <= 1'b0;
    end else begin
      fin_q  <= fin_now;
      done_q <= fin_q;
      if (fin_now) begin
        pend_len_q <= oversize ? TRUNC_L : rsp_len_i;
      end
      if (fin_q) begin
        len_q <= pend_len_q;
      end
    end
  end

  assign accept_o    = fin_now;
  assign buf_we_o    = we_q;
  assign buf_addr_o  = addr_q;
  assign buf_wdata_o = wdata_q;
  assign rsp_len_o   = len_q;
  assign rsp_done_o  = done_q;
endmodule

// File: rtl/kcs_rsp_tag_match.sv
module kcs_rsp_tag_match
  import kcs_tm_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LEN_W = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_issue_i,
  input  logic              abort_i,
  output logic              req_valid_o,
  output logic [TAG_W-1:0]  req_tag_o,
  input  logic              rsp_valid_i,
  input  logic [TAG_W-1:0]  rsp_tag_i,
  input  logic [LEN_W-1:0]  rsp_len_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  input  logic              rsp_last_i,
  output logic              rsp_ready_o,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [BYTE_W-1:0] buf_wdata_o,
  output logic [LEN_W-1:0]  rsp_len_o,
  output logic              rsp_done_o
);
  logic [TAG_W-1:0] exp_tag;
  logic             accept;
  logic             req_valid_q;
  logic [TAG_W-1:0] req_tag_q;
  logic             ready_q;

  kcs_tag_ctr u_tag (
    .clk    (clk),
    .rst    (rst),
    .bump_i (accept || abort_i),
    .tag_o  (exp_tag)
  );

  kcs_rsp_capture #(
    .DEPTH (DEPTH),
    .LEN_W (LEN_W)
  ) u_cap (
    .clk         (clk),
    .rst         (rst),
    .exp_tag_i   (exp_tag),
    .abort_i     (abort_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_tag_i   (rsp_tag_i),
    .rsp_len_i   (rsp_len_i),
    .rsp_data_i  (rsp_data_i),
    .rsp_last_i  (rsp_last_i),
    .accept_o    (accept),
    .buf_we_o    (buf_we_o),
    .buf_addr_o  (buf_addr_o),
    .buf_wdata_o (buf_wdata_o),
    .rsp_len_o   (rsp_len_o),
    .rsp_done_o  (rsp_done_o)
  );

  // request hand-off register
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid_q <= 1'b0;
      req_tag_q   <= '0;
      ready_q     <= 1'b0;
    end else begin
      req_valid_q <= req_issue_i;
      ready_q     <= 1'b1;
      if (req_issue_i) begin
        req_tag_q <= exp_tag;
      end
    end
  end

  assign req_valid_o = req_valid_q;
  assign req_tag_o   = req_tag_q;
  assign rsp_ready_o = ready_q;
endmodule

// File: rtl/kcs_rsp_tag_match_chk.sv
module kcs_rsp_tag_match_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_issue_i,
  input logic             req_valid_o,
  input logic             rsp_valid_i,
  input logic             rsp_last_i,
  input logic             rsp_ready_o,
  input logic             buf_we_o,
  input logic [LEN_W-1:0] rsp_len_o,
  input logic             rsp_done_o,
  input logic [7:0]       exp_tag
);
  // R2
  hand_off_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> $past(req_issue_i));

  // R4
  tag_step_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_tag != $past(exp_tag)) |-> (exp_tag == 8'($past(exp_tag) + 8'd1)));

  // R5
  write_cause_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we_o |-> $past(rsp_valid_i));

  // R7
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |-> (rsp_len_o <= LEN_W'(DEPTH)));

  // R9
  ready_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> rsp_ready_o);

  // R10
  done_once_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |=> !rsp_done_o);

  // R10
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done_o |-> $past(rsp_valid_i && rsp_last_i, 2));
endmodule

bind kcs_rsp_tag_match kcs_rsp_tag_match_chk #(
  .DEPTH (DEPTH),
  .LEN_W (LEN_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_issue_i (req_issue_i),
  .req_valid_o (req_valid_o),
  .rsp_valid_i (rsp_valid_i),
  .rsp_last_i  (rsp_last_i),
  .rsp_ready_o (rsp_ready_o),
  .buf_we_o    (buf_we_o),
  .rsp_len_o   (rsp_len_o),
  .rsp_done_o  (rsp_done_o),
  .exp_tag     (exp_tag)
);

// File: tb/kcs_rsp_tag_match_tb_top.sv
`timescale 1ns/1ps
module kcs_rsp_tag_match_tb_top;
  localparam int DEPTH = 16;
  localparam int LEN_W = 8;
  localparam int AW = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_issue_i = 1'b0;
  logic             abort_i = 1'b0;
  logic             req_valid_o;
  logic [7:0]       req_tag_o;
  logic             rsp_valid_i = 1'b0;
  logic [7:0]       rsp_tag_i = '0;
  logic [LEN_W-1:0] rsp_len_i = '0;
  logic [7:0]       rsp_data_i = '0;
  logic             rsp_last_i = 1'b0;
  logic             rsp_ready_o;
  logic             buf_we_o;
  logic [AW-1:0]    buf_addr_o;
  logic [7:0]       buf_wdata_o;
  logic [LEN_W-1:0] rsp_len_o;
  logic             rsp_done_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] tag_m = 8'd0;
  logic [7:0] mem [DEPTH];
  int wr_count = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  kcs_rsp_tag_match #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (.*);

  // model of the response buffer fed by the write port
  always @(posedge clk) begin
    if (buf_we_o) begin
      mem[buf_addr_o] <= buf_wdata_o;
      wr_count <= wr_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int write_limit(input int len);
    return (len > DEPTH) ? 3 : len;
  endfunction

  // query the expected tag through a request hand-off
  task automatic issue_req();
    @(negedge clk) req_issue_i = 1'b1;
    @(negedge clk) req_issue_i = 1'b0;
    chk(req_valid_o == 1'b1, "R2 hand-off strobe", req_valid_o, 1);
    chk(req_tag_o == tag_m, "R2 R4 request tag", req_tag_o, tag_m);
    @(negedge clk);
    chk(req_valid_o == 1'b0, "R2 strobe length", req_valid_o, 0);
  endtask

  task automatic do_abort();
    @(negedge clk) abort_i = 1'b1;
    @(negedge clk) abort_i = 1'b0;
    tag_m = tag_m + 8'd1; // R6
  endtask

  // abort_at < 0: no abort during the message
  task automatic send_msg(input logic [7:0] tag, input int len, input int abort_at);
    logic [7:0] d [64];
    int wc0;
    int lim;
    int exp_w;
    bit accepted;
    bit match;
    match = (tag == tag_m);
    lim = write_limit(len);
    for (int i = 0; i < len; i++) d[i] = 8'($urandom);
    if (!match) exp_w = 0;
    else if (abort_at >= 0) exp_w = (abort_at < lim) ? abort_at : lim;
    else exp_w = lim;
    accepted = match && (abort_at < 0);
    @(negedge clk);
    wc0 = wr_count;
    for (int i = 0; i < len; i++) begin
      rsp_valid_i = 1'b1;
      rsp_tag_i = tag;
      rsp_len_i = LEN_W'(len);
      rsp_data_i = d[i];
      rsp_last_i = (i == len - 1);
      abort_i = (i == abort_at);
      @(negedge clk);
      chk(rsp_ready_o == 1'b1, "R9 ready", rsp_ready_o, 1);
    end
    rsp_valid_i = 1'b0;
    rsp_last_i = 1'b0;
    abort_i = 1'b0;
    if (abort_at >= 0 || accepted) tag_m = tag_m + 8'd1;
    chk(rsp_done_o == 1'b0, "R10 pulse not early", rsp_done_o, 0);
    @(negedge clk);
    if (accepted) begin
      chk(rsp_done_o == 1'b1, "R10 ready pulse", rsp_done_o, 1);
      chk(int'(rsp_len_o) == lim, (len > DEPTH) ? "R7 length 3" :
          (len == DEPTH) ? "R8 full length" : "R3 length", rsp_len_o, lim);
    end else begin
      chk(rsp_done_o == 1'b0, match ? "R6 no pulse after abort" : "R5 no pulse",
          rsp_done_o, 0);
    end
    chk(wr_count - wc0 == exp_w, match ? ((abort_at >= 0) ? "R6 write count" :
        (len > DEPTH) ? "R7 write count" : "R3 write count") : "R5 no writes",
        wr_count - wc0, exp_w);
    for (int i = 0; i < exp_w; i++) begin
      logic [7:0] e;
      e = (len > DEPTH && i == 2) ? 8'hCA : d[i];
      chk(mem[i] == e, (len > DEPTH) ? "R7 buffer byte" :
          (len == DEPTH) ? "R8 buffer byte" : "R3 buffer byte", mem[i], e);
    end
    @(negedge clk);
    chk(rsp_done_o == 1'b0, "R10 single cycle", rsp_done_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(req_valid_o == 1'b0, "R1 strobe", req_valid_o, 0);
    chk(buf_we_o == 1'b0, "R1 write enable", buf_we_o, 0);
    chk(rsp_done_o == 1'b0, "R1 pulse", rsp_done_o, 0);
    chk(rsp_len_o == '0, "R1 length", rsp_len_o, 0);
    issue_req();

    // directed cases
    send_msg(tag_m, 5, -1);          // R3 R4
    issue_req();
    send_msg(tag_m + 8'd7, 6, -1);   // R5 mismatch
    issue_req();
    send_msg(tag_m, DEPTH, -1);      // R8 exact fit
    send_msg(tag_m, DEPTH + 1, -1);  // R7 one over
    send_msg(tag_m, 40, -1);         // R7 far over
    issue_req();
    send_msg(tag_m, 8, 3);           // R6 abort mid-message
    issue_req();
    begin
      logic [7:0] stale;
      stale = tag_m;
      do_abort();                    // R6 stale reply dropped
      send_msg(stale, 4, -1);
      issue_req();
    end
    send_msg(tag_m, 1, -1);          // R3 single byte

    // R4 wrap
    while (tag_m != 8'd255) do_abort();
    issue_req();
    send_msg(tag_m, 3, -1);
    issue_req();

    // random mix
    for (int n = 0; n < 60; n++) begin
      int kind;
      int len;
      kind = $urandom_range(0, 4);
      len = $urandom_range(1, 24);
      case (kind)
        0, 1: send_msg(tag_m, len, -1);
        2: send_msg(tag_m ^ 8'(1 << $urandom_range(0, 7)), len, -1);
        3: send_msg(tag_m, len, $urandom_range(0, len - 1));
        default: do_abort();
      endcase
      issue_req();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule